// File: doc/BRIEF.md
# Multi-Mode Serial Baud Tick Generator

This block turns a system clock into the bit-rate strobes that a serial transmitter and receiver need. An 8-bit period value N, loaded through a write strobe, sets the reload of a free-running down-counter. Two mode inputs then choose the overall clock-to-baud divisor: 64·(N+1) for slow asynchronous framing, 16·(N+1) for fast asynchronous framing, and 4·(N+1) for synchronous master clocking. In synchronous mode the speed input has no effect.

The block drives two outputs. The baud tick marks each bit period. The oversampling tick runs at sixteen times the baud rate in either asynchronous mode, so a receiver can sample within each bit. Both ticks are single-cycle strobes and appear only while the enable input is high. A period write or a change of the effective mode restarts every counter at once, so a new rate takes effect without waiting for the old count to run out. For example, with a 16 MHz clock, slow asynchronous mode and N = 25, the divisor is 1664 and the baud rate is 9615, about 0.16 % above 9600.

Top module: `baud_tick_gen`

## Requirements
- R1: Synchronous active-high reset clears the period to 0 and selects slow asynchronous mode. Both ticks are low during reset. Once enabled afterwards, the baud tick repeats every 64 cycles.
- R2: In asynchronous mode with high_speed_i = 0, the baud tick repeats every 64·(N+1) enabled cycles and the oversampling tick every 4·(N+1) enabled cycles. With N = 25 the baud interval is 1664 cycles.
- R3: In asynchronous mode with high_speed_i = 1, the baud tick repeats every 16·(N+1) enabled cycles and the oversampling tick every (N+1) enabled cycles. With N = 0 the oversampling tick is high on every enabled cycle.
- R4: In synchronous mode (sync_mode_i = 1), the baud tick repeats every 4·(N+1) enabled cycles and the oversampling tick stays low. Toggling high_speed_i in this mode changes nothing.
- R5: A period write restarts all counting at the clock edge that takes it. The first baud tick then falls on the D-th enabled cycle counted from that edge, where D is the current divisor.
- R6: While en_i is low, neither tick is asserted and all counters hold. Counting resumes from the held phase when en_i returns high.
- R7: The baud tick is never high on two consecutive cycles. In asynchronous mode every baud tick coincides with an oversampling tick.
- R8: A change of the effective mode restarts all counting, exactly as a period write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Count enable; ticks only while high |
| period_wr_i | input | 1 | Loads period_data_i and restarts counting |
| period_data_i | input | 8 | New period value N (0 to 255) |
| sync_mode_i | input | 1 | 1 = synchronous master, 0 = asynchronous |
| high_speed_i | input | 1 | Asynchronous speed select; ignored when sync_mode_i = 1 |
| baud_tick_o | output | 1 | One-cycle strobe per bit period |
| os_tick_o | output | 1 | One-cycle strobe at 16x the baud rate (asynchronous only) |

## Verification
The hardest situation to reach from the ports is a restart that lands partway through a long count. This happens when a period write or a mode change arrives after the pre-divider and post-divider have both advanced but before either wraps. The stimulus waits for a baud tick, lets a known number of enabled cycles pass, and then writes or switches mode. It also pauses en_i inside a count to freeze the phase. A behavioural model that counts enabled cycles since the last restart predicts both ticks on every clock. Explicit interval checks confirm the first tick after each restart.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

   typedef enum logic [1:0] {
      MODE_ASYNC_LO = 2'd0,
      MODE_ASYNC_HI = 2'd1,
      MODE_SYNC     = 2'd2
   } bmode_e;

   // the speed select only matters when the link is asynchronous
   function automatic bmode_e decode_mode(input logic sync_sel, input logic fast_sel);
      if (sync_sel)      return MODE_SYNC;
      else if (fast_sel) return MODE_ASYNC_HI;
      else               return MODE_ASYNC_LO;
   endfunction

endpackage

// File: rtl/baud_prediv.sv
module baud_prediv #(
   parameter int DIV = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic en_i,
   input  logic bypass_i,
   output logic step_o
);

   if (DIV < 1) begin : g_bad_div
      $error("baud_prediv: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_none
      assign step_o = en_i;
   end else begin : g_cnt
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] ph_q;

      always_ff @(posedge clk_i) begin
         if (rst_i || clr_i)  ph_q <= '0;
         else if (en_i)       ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
      end

      assign step_o = en_i & (bypass_i | (ph_q == LAST));
   end

endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         clr_i,
   input  logic [W-1:0] load_i,
   input  logic [W-1:0] reload_i,
   input  logic         step_i,
   output logic         wrap_o
);

   if (W < 1) begin : g_bad_w
      $error("baud_period_cnt: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       cnt_q <= '0;
      else if (clr_i)  cnt_q <= load_i;
      else if (step_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
   end

   assign wrap_o = step_i & (cnt_q == '0);

endmodule

// File: rtl/baud_postdiv.sv
module baud_postdiv #(
   parameter int WIDE_RATIO   = 16,
   parameter int NARROW_RATIO = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic step_i,
   input  logic narrow_i,
   output logic tick_o
);

   localparam int W = (WIDE_RATIO > 1) ? $clog2(WIDE_RATIO) : 1;
   localparam logic [W-1:0] WIDE_LAST   = W'(WIDE_RATIO - 1);
   localparam logic [W-1:0] NARROW_LAST = W'(NARROW_RATIO - 1);

   if ((WIDE_RATIO & (WIDE_RATIO - 1)) != 0 || WIDE_RATIO < 2) begin : g_bad_wide
      $error("baud_postdiv: WIDE_RATIO must be a power of two, at least 2");
   end
   if (NARROW_RATIO < 2 || NARROW_RATIO > WIDE_RATIO) begin : g_bad_narrow
      $error("baud_postdiv: NARROW_RATIO must lie in 2..WIDE_RATIO");
   end

   logic [W-1:0] div_q;
   logic [W-1:0] last;

   assign last = narrow_i ? NARROW_LAST : WIDE_LAST;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) div_q <= '0;
      else if (step_i)    div_q <= (div_q == last) ? '0 : div_q + 1'b1;
   end

   assign tick_o = step_i & (div_q == last);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_tick_pkg::*;
#(
   parameter int PERIOD_W    = 8,
   parameter int SLOW_PREDIV = 4,
   parameter int OS_RATIO    = 16,
   parameter int SYNC_RATIO  = 4
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                en_i,
   input  logic                period_wr_i,
   input  logic [PERIOD_W-1:0] period_data_i,
   input  logic                sync_mode_i,
   input  logic                high_speed_i,
   output logic                baud_tick_o,
   output logic                os_tick_o
);

   if (PERIOD_W < 1 || PERIOD_W > 16) begin : g_bad_period_w
      $error("baud_tick_gen: PERIOD_W out of range");
   end

   bmode_e              mode_q;
   bmode_e              mode_next;
   logic                restart;
   logic [PERIOD_W-1:0] period_q;
   logic [PERIOD_W-1:0] load_val;
   logic                pre_step;
   logic                cnt_wrap;

   assign mode_next = decode_mode(sync_mode_i, high_speed_i);
   assign restart   = period_wr_i | (mode_next != mode_q);
   assign load_val  = period_wr_i ? period_data_i : period_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mode_q   <= MODE_ASYNC_LO;
         period_q <= '0;
      end else begin
         mode_q <= mode_next;
         if (period_wr_i) period_q <= period_data_i;
      end
   end

   baud_prediv #(.DIV(SLOW_PREDIV)) u_prediv (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .clr_i    (restart),
      .en_i     (en_i),
      .bypass_i (mode_q != MODE_ASYNC_LO),
      .step_o   (pre_step)
   );

   baud_period_cnt #(.W(PERIOD_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .clr_i    (restart),
      .load_i   (load_val),
      .reload_i (period_q),
      .step_i   (pre_step),
      .wrap_o   (cnt_wrap)
   );

   baud_postdiv #(.WIDE_RATIO(OS_RATIO), .NARROW_RATIO(SYNC_RATIO)) u_post (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .clr_i    (restart),
      .step_i   (cnt_wrap),
      .narrow_i (mode_q == MODE_SYNC),
      .tick_o   (baud_tick_o)
   );

   assign os_tick_o = cnt_wrap & (mode_q != MODE_SYNC);

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk
   import baud_tick_pkg::*;
(
   input logic   clk_i,
   input logic   rst_i,
   input logic   en_i,
   input logic   period_wr_i,
   input logic   sync_mode_i,
   input logic   high_speed_i,
   input logic   baud_tick_o,
   input logic   os_tick_o,
   input bmode_e mode_q
);

   // R1: reset leaves every counter at its start, so no tick the cycle after
   a_r1_quiet_after_reset: assert property (@(posedge clk_i)
      rst_i |=> (!baud_tick_o && !os_tick_o));

   // R6: ticks need the enable
   a_r6_idle_no_tick: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |-> (!baud_tick_o && !os_tick_o));

   // R7: single-cycle baud strobe
   a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
      baud_tick_o |=> !baud_tick_o);

   // R7: in asynchronous framing a bit boundary is also an oversampling point
   a_r7_baud_on_os: assert property (@(posedge clk_i) disable iff (rst_i)
      (baud_tick_o && mode_q != MODE_SYNC) |-> os_tick_o);

   // R4: synchronous mode has no oversampling strobe
   a_r4_sync_no_os: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_q == MODE_SYNC) |-> !os_tick_o);

   // R5: a write restarts counting, so the next cycle cannot end a bit
   a_r5_write_restarts: assert property (@(posedge clk_i) disable iff (rst_i)
      period_wr_i |=> !baud_tick_o);

   // R8: an effective mode change restarts counting as well
   a_r8_mode_restarts: assert property (@(posedge clk_i) disable iff (rst_i)
      (decode_mode(sync_mode_i, high_speed_i) != mode_q) |=> !baud_tick_o);

endmodule

bind baud_tick_gen baud_tick_chk chk_i (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .en_i         (en_i),
   .period_wr_i  (period_wr_i),
   .sync_mode_i  (sync_mode_i),
   .high_speed_i (high_speed_i),
   .baud_tick_o  (baud_tick_o),
   .os_tick_o    (os_tick_o),
   .mode_q       (mode_q)
);

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'd0;
   logic       sync_sel = 1'b0;
   logic       fast_sel = 1'b0;
   logic       baud;
   logic       os;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   // reference model state
   int m_j = 0;
   int m_n = 0;
   int m_md = 0;
   bit prev_baud = 1'b0;
   int dbl_count = 0;

   always #4 clk = ~clk;

   baud_tick_gen dut_i (
      .clk_i         (clk),
      .rst_i         (rst),
      .en_i          (en),
      .period_wr_i   (wr),
      .period_data_i (wdata),
      .sync_mode_i   (sync_sel),
      .high_speed_i  (fast_sel),
      .baud_tick_o   (baud),
      .os_tick_o     (os)
   );

   function automatic int mode_of(input bit s, input bit f);
      return s ? 2 : (f ? 1 : 0);
   endfunction

   function automatic int os_div(input int md, input int n);
      return ((md == 0) ? 4 : 1) * (n + 1);
   endfunction

   function automatic int full_div(input int md, input int n);
      return os_div(md, n) * ((md == 2) ? 4 : 16);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // model advance, same edge as the design
   always @(posedge clk) begin
      if (rst) begin
         m_j = 0; m_n = 0; m_md = 0;
      end else begin
         int nm;
         nm = mode_of(sync_sel, fast_sel);
         if (wr || nm != m_md) begin
            m_j = 0;
            if (wr) m_n = wdata;
            m_md = nm;
         end else if (en) begin
            m_j++;
         end
      end
   end

   // per-clock comparison at the falling edge
   always @(negedge clk) begin
      if (!rst) begin
         bit eb, eo;
         eb = en && (((m_j + 1) % full_div(m_md, m_n)) == 0);
         eo = en && (m_md != 2) && (((m_j + 1) % os_div(m_md, m_n)) == 0);
         check(baud === eb, {cur_req, " baud"}, int'(baud), int'(eb));
         check(os === eo, {cur_req, " os"}, int'(os), int'(eo));
         if (baud && prev_baud) dbl_count++;
         prev_baud = baud;
      end
   end

   task automatic wait_baud();
      do @(negedge clk); while (!baud);
   endtask

   task automatic gap_baud(input int exp, input string req);
      int n;
      wait_baud();
      n = 0;
      do begin @(negedge clk); n++; end while (!baud);
      check(n == exp, {req, " baud interval"}, n, exp);
   endtask

   task automatic gap_os(input int exp, input string req);
      int n;
      do @(negedge clk); while (!os);
      n = 0;
      do begin @(negedge clk); n++; end while (!os);
      check(n == exp, {req, " os interval"}, n, exp);
   endtask

   task automatic write_period(input int v);
      @(negedge clk); #1 wr = 1'b1; wdata = 8'(v);
      @(negedge clk); #1 wr = 1'b0;
   endtask

   task automatic set_mode(input bit s, input bit f);
      @(negedge clk); #1 sync_sel = s; fast_sel = f;
   endtask

   // count cycles from the current (restart) negedge to the first tick
   task automatic first_tick(input int exp, input string req);
      int n;
      n = 1;
      while (!baud) begin @(negedge clk); n++; end
      check(n == exp, {req, " first tick after restart"}, n, exp);
   endtask

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      check(baud === 1'b0 && os === 1'b0, "R1 outputs in reset", int'(baud), 0);
      #1 rst = 1'b0;

      // R6: nothing while disabled
      cur_req = "R6";
      seen = 0;
      repeat (100) begin @(negedge clk); if (baud || os) seen++; end
      check(seen == 0, "R6 ticks while disabled", seen, 0);

      // R1: default period 0, slow asynchronous
      cur_req = "R1";
      #1 en = 1'b1;
      gap_baud(64, "R1");

      // R2: slow asynchronous
      cur_req = "R2";
      write_period(25);
      gap_baud(1664, "R2");
      gap_os(104, "R2");
      write_period(255);
      gap_baud(16384, "R2");

      // R3: fast asynchronous
      cur_req = "R3";
      set_mode(1'b0, 1'b1);
      write_period(0);
      gap_baud(16, "R3");
      seen = 0;
      repeat (5) begin @(negedge clk); if (os) seen++; end
      check(seen == 5, "R3 os every cycle at N=0", seen, 5);
      write_period(255);
      gap_baud(4096, "R3");

      // R4: synchronous
      cur_req = "R4";
      set_mode(1'b1, 1'b0);
      write_period(0);
      gap_baud(4, "R4");
      write_period(7);
      gap_baud(32, "R4");
      wait_baud();
      repeat (10) @(negedge clk);
      #1 fast_sel = 1'b1;
      gap_baud(32, "R4 speed ignored");
      seen = 0;
      repeat (200) begin @(negedge clk); if (os) seen++; end
      check(seen == 0, "R4 os in sync", seen, 0);
      write_period(255);
      gap_baud(1024, "R4");

      // R5: mid-count write restarts
      cur_req = "R5";
      set_mode(1'b0, 1'b1);
      write_period(9);
      wait_baud();
      repeat (50) @(negedge clk);
      #1 wr = 1'b1; wdata = 8'd9;
      @(negedge clk); #1 wr = 1'b0;
      first_tick(160, "R5");

      // R6: pause holds phase
      cur_req = "R6";
      wait_baud();
      repeat (40) @(negedge clk);
      #1 en = 1'b0;
      seen = 0;
      repeat (37) begin @(negedge clk); if (baud || os) seen++; end
      check(seen == 0, "R6 ticks while paused", seen, 0);
      #1 en = 1'b1;
      seen = 0;
      do begin @(negedge clk); seen++; end while (!baud);
      check(seen == 160 - 40, "R6 resume phase", seen, 120);

      // R8: mode change mid-count restarts
      cur_req = "R8";
      wait_baud();
      repeat (70) @(negedge clk);
      #1 sync_sel = 1'b1;
      @(negedge clk);
      first_tick(40, "R8");

      check(dbl_count == 0, "R7 double-width baud", dbl_count, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 8);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule